// File: doc/BRIEF.md
# Sensor-Gated Two-Road Light Controller

This block drives the lamps of a junction where a North-South road crosses an East-West road. Each road has only a green and a red lamp, and exactly one road is green at any moment. A car-presence detector on each road tells the controller whether traffic is waiting. The controller hands the green to the other road only when a car waits on that road.

The controller does not decide on every clock. An internal prescaler divides the system clock into a one-cycle update tick every `TICK_CYCLES` clocks. With a real clock this period is set to give a 30-second interval; the small default keeps simulation short. The state register loads only on the tick edge. Both detector inputs pass through a two-flop synchroniser before the state machine sees them. The lamps are decoded from the state alone.

Top module: `tlc_junction`

## Requirements
- R1: While `rst_ni` is low, North-South shows green and East-West shows red. The prescaler is cleared, so the first state update after reset falls on the `TICK_CYCLES`-th rising edge after release.
- R2: Exactly one of `ns_green_o` and `ew_green_o` is 1 at all times, and each road's red output is the inverse of its green output.
- R3: Lamp outputs change only on update edges. These fall every `TICK_CYCLES` clocks, and the outputs stay constant on all other edges.
- R4: With North-South green, an update edge that sees the East-West detector at 1 moves the green to East-West.
- R5: With North-South green, an update edge that sees the East-West detector at 0 keeps North-South green, whatever the North-South detector reads.
- R6: With East-West green, an update edge that sees the North-South detector at 1 moves the green to North-South.
- R7: With East-West green, an update edge that sees the North-South detector at 0 keeps East-West green, whatever the East-West detector reads.
- R8: The detector value used at an update edge is the one that was present at the input two rising edges earlier. A change that arrives after that edge waits for the next interval.
- R9: The update tick is one clock wide and repeats with a period of exactly `TICK_CYCLES` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_ns_i | input | 1 | North-South car detector, 1 = car waiting |
| car_ew_i | input | 1 | East-West car detector, 1 = car waiting |
| ns_green_o | output | 1 | North-South green lamp |
| ns_red_o | output | 1 | North-South red lamp |
| ew_green_o | output | 1 | East-West green lamp |
| ew_red_o | output | 1 | East-West red lamp |

## Verification
The transition assertions compare the state with the synchronised detector bits, not with the raw pins. They therefore assume nothing about when the detectors change relative to the tick. The check that the state is stable between ticks relies on `TICK_CYCLES` being at least 4, which the prescaler enforces when it elaborates. The stimulus changes the detectors only on falling clock edges. It holds each base value for a whole interval and places each late change at a chosen cycle, so the bench knows which edge should first see it. Random intervals are mixed with a directed walk through all eight rows of the transition table.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic {
    GREEN_NS = 1'b0,
    GREEN_EW = 1'b1
  } road_e;
endpackage

// File: rtl/tlc_prescaler.sv
module tlc_prescaler #(
  parameter int unsigned TICK_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  initial begin
    if (TICK_CYCLES < 4) $error("TICK_CYCLES must be at least 4");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  a_r9_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r9_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/tlc_sync.sv
module tlc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tlc_fsm.sv
module tlc_fsm
  import tlc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  car_ns_i,
  input  logic  car_ew_i,
  output road_e green_o
);
  road_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      GREEN_NS: if (car_ew_i) state_d = GREEN_EW;
      GREEN_EW: if (car_ns_i) state_d = GREEN_NS;
      default:  state_d = GREEN_NS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= GREEN_NS;
    else if (tick_i) state_q <= state_d;
  end

  assign green_o = state_q;

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
  a_r4_ns_to_ew: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == GREEN_NS && car_ew_i) |=> state_q == GREEN_EW);
  a_r5_ns_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == GREEN_NS && !car_ew_i) |=> state_q == GREEN_NS);
  a_r6_ew_to_ns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == GREEN_EW && car_ns_i) |=> state_q == GREEN_NS);
  a_r7_ew_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == GREEN_EW && !car_ns_i) |=> state_q == GREEN_EW);
endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
  import tlc_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_ns_i,
  input  logic car_ew_i,
  output logic ns_green_o,
  output logic ns_red_o,
  output logic ew_green_o,
  output logic ew_red_o
);
  logic       tick;
  logic [1:0] car_s;
  road_e      green;

  tlc_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  // bit 1: north-south detector, bit 0: east-west detector
  tlc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({car_ns_i, car_ew_i}),
    .q_o   (car_s)
  );

  tlc_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .car_ns_i(car_s[1]),
    .car_ew_i(car_s[0]),
    .green_o (green)
  );

  assign ns_green_o = (green == GREEN_NS);
  assign ew_green_o = (green == GREEN_EW);
  assign ns_red_o   = ~ns_green_o;
  assign ew_red_o   = ~ew_green_o;

  a_r2_one_green: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ns_green_o, ew_green_o}) == 1);
  a_r2_red_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_red_o != ns_green_o) && (ew_red_o != ew_green_o));
  a_r3_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable({ns_green_o, ew_green_o}));
endmodule

// File: tb/sim_tlc_junction.sv
`timescale 1ns/1ps
module sim_tlc_junction;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic car_ns = 1'b0, car_ew = 1'b0;
  logic ns_g, ns_r, ew_g, ew_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_ew = 1'b0;  // 0: north-south green, 1: east-west green

  always #2 clk = ~clk;  // 250 MHz

  tlc_junction #(.TICK_CYCLES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .car_ns_i(car_ns), .car_ew_i(car_ew),
    .ns_green_o(ns_g), .ns_red_o(ns_r), .ew_green_o(ew_g), .ew_red_o(ew_r)
  );

  function automatic logic [3:0] lamps_for(bit ew_green);
    return ew_green ? 4'b0110 : 4'b1001;  // {ns_g, ns_r, ew_g, ew_r}
  endfunction

  function automatic bit next_road(bit cur, bit ns, bit ew);
    if (!cur) return ew ? 1'b1 : 1'b0;
    return ns ? 1'b0 : 1'b1;
  endfunction

  task automatic check_lamps(string tag, logic [3:0] expv);
    logic [3:0] act;
    act = {ns_g, ns_r, ew_g, ew_r};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s lamps act=%b exp=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // Drive base values for one interval; after rising edge late_cyc drive late values.
  task automatic run_interval(bit b_ns, bit b_ew, int late_cyc, bit l_ns, bit l_ew);
    bit prev, eff_ns, eff_ew;
    string tag;
    car_ns = b_ns; car_ew = b_ew;
    prev = exp_ew;
    // R8: value present at edge N-2 is the one used at edge N
    if (late_cyc <= N - 3) begin eff_ns = l_ns; eff_ew = l_ew; end
    else                   begin eff_ns = b_ns; eff_ew = b_ew; end
    if (!prev) tag = eff_ew ? "R4" : "R5";
    else       tag = eff_ns ? "R6" : "R7";
    if (late_cyc < N) tag = {tag, "/R8"};
    for (int c = 1; c <= N; c++) begin
      @(negedge clk);
      if (c < N) check_lamps("R3/R9 hold", lamps_for(prev));
      else begin
        exp_ew = next_road(prev, eff_ns, eff_ew);
        check_lamps({tag, " update R2"}, lamps_for(exp_ew));
      end
      if (c == late_cyc) begin car_ns = l_ns; car_ew = l_ew; end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_lamps("R1 reset", lamps_for(1'b0));
    rst_ni = 1'b1;  // released at a falling edge

    // R1: first update exactly N edges after release; directed 8-row walk
    run_interval(0, 1, N, 0, 0);  // NS, ew=1 -> EW (R4)
    run_interval(0, 0, N, 0, 0);  // EW, none  -> EW (R7)
    run_interval(0, 1, N, 0, 0);  // EW, ew=1  -> EW (R7)
    run_interval(1, 1, N, 0, 0);  // EW, both  -> NS (R6)
    run_interval(0, 0, N, 0, 0);  // NS, none  -> NS (R5)
    run_interval(1, 0, N, 0, 0);  // NS, ns=1  -> NS (R5)
    run_interval(1, 1, N, 0, 0);  // NS, both  -> EW (R4)
    run_interval(1, 0, N, 0, 0);  // EW, ns=1  -> NS (R6)

    // R8 corner: late arrival missed, then picked up next interval
    run_interval(0, 0, N - 2, 0, 1);  // too late: stay NS
    run_interval(0, 1, N, 0, 0);      // now switch to EW
    run_interval(0, 0, N - 3, 1, 0);  // just in time: to NS
    run_interval(0, 1, N - 3, 0, 0);  // ew withdrawn in time: stay NS

    // random intervals
    for (int i = 0; i < 200; i++) begin
      bit bns, bew, lns, lew;
      int lc;
      bns = 1'($urandom); bew = 1'($urandom);
      lns = 1'($urandom); lew = 1'($urandom);
      lc = (($urandom % 3) == 0) ? N : int'($urandom % (N - 1)) + 1;
      run_interval(bns, bew, lc, lns, lew);
    end

    // R1 again: asynchronous reset mid-interval returns NS green
    car_ns = 1'b0; car_ew = 1'b1;
    run_interval(0, 1, N, 0, 0);
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    exp_ew = 1'b0;
    check_lamps("R1 reset mid-run", lamps_for(1'b0));
    @(negedge clk);
    rst_ni = 1'b1;
    run_interval(0, 1, N, 0, 0);  // prescaler cleared: switch at edge N

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule